// File: doc/BRIEF.md
# Next Program Counter Selector

This block holds the program counter and works out, every cycle, which address the next instruction comes from. A decoder upstream supplies a transfer kind and its operands: the length of the current instruction, a full-width target, a short signed displacement, and a value read from a register. The block also gets the operands of a branch condition. The condition can be an equality test on two register values, a test of one register value against zero, or a status flag that an earlier instruction stored. From these it forms the following address and a flag that says whether a non-sequential transfer was taken.

The next address is visible combinationally on `next_pc_o` in the same cycle as the inputs. The program counter register loads it on a rising clock edge while `en` is high. When `en` is low the register holds its value, which lets a stalled pipeline freeze fetch. There is no data stream at the edge of this block. All pins are plain control and data levels sampled at the clock edge, so no valid/ready handshake and no back-pressure apply.

Top module: `nextpc_sel`

## Requirements
- R1: A clock edge with `rst` high sets `pc_o` to 0x0000, whatever `en` is.
- R2: A clock edge with `rst` low and `en` low leaves `pc_o` unchanged, even when `next_pc_o` differs from it.
- R3: Sequential kind (`kind`=0) gives `next_pc_o` = `pc_o` + `instr_len`, with `taken_o` low.
- R4: Absolute kind (`kind`=1) with a true condition gives `next_pc_o` = `abs_tgt` unchanged.
- R5: Relative kind (`kind`=2) with a true condition gives `next_pc_o` = `pc_o` + `instr_len` + the 10-bit `rel_off` sign-extended to 16 bits, modulo 2^16, so backward and wrapping targets work.
- R6: Indirect kind (`kind`=3) with a true condition gives `next_pc_o` = `ind_val`.
- R7: Skip kind (`kind`=4) with a true condition gives `next_pc_o` = `pc_o` + `instr_len` + 1, modulo 2^16.
- R8: For kinds 1 to 4, a false condition gives the sequential address `pc_o` + `instr_len` and `taken_o` low. A true condition drives `taken_o` high.
- R9: `cond_sel` picks the condition as follows: 0 is always true, 1 is `cmp_a` == `cmp_b`, 2 is `cmp_a` == 0, and 3 is `flag_in`.
- R10: The unused kind codes 5, 6 and 7 act as sequential: `next_pc_o` = `pc_o` + `instr_len` and `taken_o` low, whatever the condition is.
- R11: A clock edge with `rst` low and `en` high loads `pc_o` with the `next_pc_o` value present before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Program counter update enable |
| kind | input | 3 | Transfer kind: 0 seq, 1 abs, 2 rel, 3 indirect, 4 skip |
| cond_sel | input | 2 | Condition source: 0 always, 1 equal, 2 zero, 3 flag |
| instr_len | input | 3 | Length of the current instruction in address units |
| abs_tgt | input | 16 | Absolute target address |
| rel_off | input | 10 | Signed relative displacement |
| ind_val | input | 16 | Register value used as the indirect target |
| cmp_a | input | 16 | First compare operand |
| cmp_b | input | 16 | Second compare operand |
| flag_in | input | 1 | Stored status flag |
| pc_o | output | 16 | Current program counter |
| next_pc_o | output | 16 | Selected next address |
| taken_o | output | 1 | A non-sequential transfer is selected |

## Verification
A fault in the target arithmetic or the selection shows up on `next_pc_o` and `taken_o` in the same cycle as the stimulus, before any clock edge. A fault in the register shows up on `pc_o` one edge later. It then corrupts every later address, because each sequential step adds to the bad value. For that reason each step is checked twice: once combinationally after the inputs settle, and once for `pc_o` after the following edge. The stimulus covers every condition source with both a true and a false outcome, a backward displacement, a wrap past 0xFFFF, a frozen update and the unused kind codes.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [2:0] {
    XFER_SEQ  = 3'd0,
    XFER_ABS  = 3'd1,
    XFER_REL  = 3'd2,
    XFER_IND  = 3'd3,
    XFER_SKIP = 3'd4
  } xfer_kind_e;

  typedef enum logic [1:0] {
    CSRC_ALWAYS = 2'd0,
    CSRC_EQUAL  = 2'd1,
    CSRC_ZERO   = 2'd2,
    CSRC_FLAG   = 2'd3
  } cond_src_e;

  localparam int unsigned SKIP_STEP = 1;

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              flag,
  output logic              hit
);

  logic eq_hit;
  logic zero_hit;

  assign eq_hit   = (opa == opb);
  assign zero_hit = ~|opa;

  always_comb begin
    unique case (cond_src_e'(sel))
      CSRC_ALWAYS: hit = 1'b1;
      CSRC_EQUAL:  hit = eq_hit;
      CSRC_ZERO:   hit = zero_hit;
      CSRC_FLAG:   hit = flag;
      default:     hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/npc_target_calc.sv
module npc_target_calc
  import npc_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFF_W = 10,
  parameter int unsigned LEN_W = 3
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [LEN_W-1:0] len,
  input  logic [OFF_W-1:0] off,
  output logic [PC_W-1:0]  seq_addr,
  output logic [PC_W-1:0]  rel_addr,
  output logic [PC_W-1:0]  skip_addr
);

  localparam int unsigned EXT_W = (PC_W > OFF_W) ? PC_W - OFF_W : 1;

  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] len_ext;

  generate
    if (PC_W > OFF_W) begin : g_sext
      assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
    end else begin : g_trunc
      assign off_ext = off[PC_W-1:0];
    end
    if (PC_W > LEN_W) begin : g_lzext
      assign len_ext = {{(PC_W-LEN_W){1'b0}}, len};
    end else begin : g_ltrunc
      assign len_ext = len[PC_W-1:0];
    end
  endgenerate

  assign seq_addr  = pc + len_ext;
  assign rel_addr  = seq_addr + off_ext;
  assign skip_addr = seq_addr + PC_W'(SKIP_STEP);

endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int unsigned PC_W = 16
) (
  input  logic [2:0]      kind,
  input  logic            cond_hit,
  input  logic [PC_W-1:0] seq_addr,
  input  logic [PC_W-1:0] abs_addr,
  input  logic [PC_W-1:0] rel_addr,
  input  logic [PC_W-1:0] ind_addr,
  input  logic [PC_W-1:0] skip_addr,
  output logic [PC_W-1:0] next_addr,
  output logic            taken
);

  logic            kind_xfer;
  logic [PC_W-1:0] xfer_addr;

  always_comb begin
    kind_xfer = 1'b1;
    xfer_addr = seq_addr;
    case (xfer_kind_e'(kind))
      XFER_ABS:  xfer_addr = abs_addr;
      XFER_REL:  xfer_addr = rel_addr;
      XFER_IND:  xfer_addr = ind_addr;
      XFER_SKIP: xfer_addr = skip_addr;
      default:   kind_xfer = 1'b0;
    endcase
  end

  assign taken     = kind_xfer & cond_hit;
  assign next_addr = taken ? xfer_addr : seq_addr;

endmodule

// File: rtl/nextpc_sel.sv
module nextpc_sel
  import npc_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFF_W = 10,
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [2:0]       kind,
  input  logic [1:0]       cond_sel,
  input  logic [LEN_W-1:0] instr_len,
  input  logic [PC_W-1:0]  abs_tgt,
  input  logic [OFF_W-1:0] rel_off,
  input  logic [PC_W-1:0]  ind_val,
  input  logic [PC_W-1:0]  cmp_a,
  input  logic [PC_W-1:0]  cmp_b,
  input  logic             flag_in,
  output logic [PC_W-1:0]  pc_o,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             taken_o
);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] seq_addr;
  logic [PC_W-1:0] rel_addr;
  logic [PC_W-1:0] skip_addr;
  logic            cond_hit;

  npc_cond_eval #(.DATA_W(PC_W)) u_cond (
    .sel  (cond_sel),
    .opa  (cmp_a),
    .opb  (cmp_b),
    .flag (flag_in),
    .hit  (cond_hit)
  );

  npc_target_calc #(.PC_W(PC_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_calc (
    .pc        (pc_q),
    .len       (instr_len),
    .off       (rel_off),
    .seq_addr  (seq_addr),
    .rel_addr  (rel_addr),
    .skip_addr (skip_addr)
  );

  npc_select #(.PC_W(PC_W)) u_sel (
    .kind      (kind),
    .cond_hit  (cond_hit),
    .seq_addr  (seq_addr),
    .abs_addr  (abs_tgt),
    .rel_addr  (rel_addr),
    .ind_addr  (ind_val),
    .skip_addr (skip_addr),
    .next_addr (next_pc_o),
    .taken     (taken_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (en) begin
      pc_q <= next_pc_o;
    end
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/nextpc_sel_chk.sv
module nextpc_sel_chk #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned LEN_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [2:0]       kind,
  input logic [LEN_W-1:0] instr_len,
  input logic [PC_W-1:0]  abs_tgt,
  input logic [PC_W-1:0]  ind_val,
  input logic [PC_W-1:0]  pc_o,
  input logic [PC_W-1:0]  next_pc_o,
  input logic             taken_o
);

  logic            armed;
  logic            rst_d;
  logic [PC_W-1:0] seq_chk;

  assign seq_chk = pc_o + PC_W'(instr_len);

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_d === 1'b1) begin
      AST_RESET_ZERO: assert (pc_o == '0); // R1
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst || !armed)
    !en |=> pc_o == $past(pc_o)); // R2

  AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (rst || !armed)
    en |=> pc_o == $past(next_pc_o)); // R11

  AST_ABS_TARGET: assert property (@(posedge clk) disable iff (rst || !armed)
    (taken_o && kind == 3'd1) |-> next_pc_o == abs_tgt); // R4

  AST_IND_TARGET: assert property (@(posedge clk) disable iff (rst || !armed)
    (taken_o && kind == 3'd3) |-> next_pc_o == ind_val); // R6

  AST_SKIP_TARGET: assert property (@(posedge clk) disable iff (rst || !armed)
    (taken_o && kind == 3'd4) |-> next_pc_o == seq_chk + PC_W'(1)); // R7

  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (rst || !armed)
    !taken_o |-> next_pc_o == seq_chk); // R8

  AST_UNDEF_KIND: assert property (@(posedge clk) disable iff (rst || !armed)
    (kind > 3'd4) |-> !taken_o); // R10

  AST_SEQ_KIND: assert property (@(posedge clk) disable iff (rst || !armed)
    (kind == 3'd0) |-> !taken_o); // R3

endmodule

bind nextpc_sel nextpc_sel_chk #(.PC_W(PC_W), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .kind      (kind),
  .instr_len (instr_len),
  .abs_tgt   (abs_tgt),
  .ind_val   (ind_val),
  .pc_o      (pc_o),
  .next_pc_o (next_pc_o),
  .taken_o   (taken_o)
);

// File: tb/tb_nextpc_sel.sv
`timescale 1ns/1ps
module tb_nextpc_sel;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [2:0]  kind = '0;
  logic [1:0]  cond_sel = '0;
  logic [2:0]  instr_len = '0;
  logic [15:0] abs_tgt = '0;
  logic [9:0]  rel_off = '0;
  logic [15:0] ind_val = '0;
  logic [15:0] cmp_a = '0;
  logic [15:0] cmp_b = '0;
  logic        flag_in = 1'b0;
  logic [15:0] pc_o;
  logic [15:0] next_pc_o;
  logic        taken_o;

  int total = 0;
  int bad = 0;
  logic [15:0] m_pc = '0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  nextpc_sel dut (
    .clk(clk), .rst(rst), .en(en), .kind(kind), .cond_sel(cond_sel),
    .instr_len(instr_len), .abs_tgt(abs_tgt), .rel_off(rel_off),
    .ind_val(ind_val), .cmp_a(cmp_a), .cmp_b(cmp_b), .flag_in(flag_in),
    .pc_o(pc_o), .next_pc_o(next_pc_o), .taken_o(taken_o)
  );

  function automatic bit cond_ok(input logic [1:0] cs, input logic [15:0] a,
                                 input logic [15:0] b, input bit f);
    case (cs)
      2'd0: return 1'b1;
      2'd1: return a == b;
      2'd2: return a == 16'd0;
      default: return f;
    endcase
  endfunction

  task automatic step(input bit r, input bit e, input logic [2:0] k,
                      input logic [1:0] cs, input logic [2:0] ln,
                      input logic [15:0] ab, input logic [9:0] of,
                      input logic [15:0] iv, input logic [15:0] a,
                      input logic [15:0] b, input bit f, input string tag);
    logic [15:0] seq_a;
    logic [15:0] exp_n;
    bit          exp_t;
    @(negedge clk);
    rst = r; en = e; kind = k; cond_sel = cs; instr_len = ln;
    abs_tgt = ab; rel_off = of; ind_val = iv; cmp_a = a; cmp_b = b; flag_in = f;
    #1;
    seq_a = m_pc + {13'd0, ln};
    exp_t = (k >= 3'd1 && k <= 3'd4) && cond_ok(cs, a, b, f);
    exp_n = seq_a;
    if (exp_t) begin
      case (k)
        3'd1: exp_n = ab;
        3'd2: exp_n = seq_a + {{6{of[9]}}, of};
        3'd3: exp_n = iv;
        default: exp_n = seq_a + 16'd1;
      endcase
    end
    total++;
    if (next_pc_o !== exp_n || taken_o !== exp_t) begin
      bad++;
      $display("FAIL %s next_pc/taken got %h/%b exp %h/%b", tag, next_pc_o, taken_o, exp_n, exp_t);
    end
    if (r) m_pc = 16'd0;
    else if (e) m_pc = exp_n;
    exp_q.push_back(m_pc);
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [15:0] ex;
        string tg;
        ex = exp_q.pop_front();
        tg = tag_q.pop_front();
        total++;
        if (pc_o !== ex) begin
          bad++;
          $display("FAIL %s pc after edge got %h exp %h", tg, pc_o, ex);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    step(1, 0, 3'd1, 2'd0, 3'd2, 16'h5555, 10'd0, 16'd0, 16'd0, 16'd0, 0, "R1 reset");
    step(1, 1, 3'd0, 2'd0, 3'd2, 16'd0, 10'd0, 16'd0, 16'd0, 16'd0, 0, "R1 reset en");
    step(0, 1, 3'd0, 2'd0, 3'd2, 16'd0, 10'd0, 16'd0, 16'd0, 16'd0, 0, "R3 seq len2 R11");
    step(0, 1, 3'd0, 2'd3, 3'd4, 16'hAAAA, 10'd0, 16'd0, 16'd0, 16'd0, 1, "R3 seq len4");
    step(0, 1, 3'd1, 2'd0, 3'd2, 16'h1234, 10'd0, 16'd0, 16'd0, 16'd0, 0, "R4 abs always");
    step(0, 1, 3'd2, 2'd0, 3'd2, 16'd0, 10'h3FB, 16'd0, 16'd0, 16'd0, 0, "R5 rel backward");
    step(0, 1, 3'd2, 2'd0, 3'd1, 16'd0, 10'd100, 16'd0, 16'd0, 16'd0, 0, "R5 rel forward");
    step(0, 1, 3'd1, 2'd0, 3'd1, 16'hFFFE, 10'd0, 16'd0, 16'd0, 16'd0, 0, "R4 abs high");
    step(0, 1, 3'd2, 2'd0, 3'd1, 16'd0, 10'd3, 16'd0, 16'd0, 16'd0, 0, "R5 rel wrap");
    step(0, 1, 3'd3, 2'd0, 3'd2, 16'd0, 10'd0, 16'hBEEF, 16'd0, 16'd0, 0, "R6 indirect");
    step(0, 1, 3'd4, 2'd1, 3'd2, 16'd0, 10'd0, 16'd0, 16'h0042, 16'h0042, 0, "R7 R9 skip equal");
    step(0, 1, 3'd4, 2'd1, 3'd2, 16'd0, 10'd0, 16'd0, 16'h0042, 16'h0043, 0, "R8 R9 skip unequal");
    step(0, 1, 3'd2, 2'd2, 3'd1, 16'd0, 10'h3F0, 16'd0, 16'd0, 16'h7777, 0, "R9 rel zero true");
    step(0, 1, 3'd2, 2'd2, 3'd1, 16'd0, 10'h3F0, 16'd0, 16'd5, 16'd0, 0, "R8 R9 rel zero false");
    step(0, 1, 3'd1, 2'd3, 3'd2, 16'h0800, 10'd0, 16'd0, 16'd1, 16'd1, 1, "R9 abs flag true");
    step(0, 1, 3'd3, 2'd3, 3'd2, 16'd0, 10'd0, 16'h9999, 16'd1, 16'd1, 0, "R8 R9 ind flag false");
    step(0, 0, 3'd1, 2'd0, 3'd2, 16'h4000, 10'd0, 16'd0, 16'd0, 16'd0, 0, "R2 hold abs");
    step(0, 0, 3'd0, 2'd0, 3'd3, 16'd0, 10'd0, 16'd0, 16'd0, 16'd0, 0, "R2 hold seq");
    step(0, 1, 3'd6, 2'd0, 3'd3, 16'h3333, 10'd7, 16'h2222, 16'd0, 16'd0, 1, "R10 kind6");
    step(0, 1, 3'd5, 2'd0, 3'd1, 16'h3333, 10'd7, 16'h2222, 16'd0, 16'd0, 1, "R10 kind5");
    step(0, 1, 3'd7, 2'd3, 3'd0, 16'h3333, 10'd7, 16'h2222, 16'd0, 16'd0, 1, "R10 kind7 len0");
    step(1, 1, 3'd1, 2'd0, 3'd2, 16'h7000, 10'd0, 16'd0, 16'd0, 16'd0, 0, "R1 reset mid run");
    step(0, 1, 3'd4, 2'd0, 3'd7, 16'd0, 10'd0, 16'd0, 16'd0, 16'd0, 0, "R7 skip after reset");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule